// File: doc/BRIEF.md
# Flash Buffered-Write Command Sequencer

This block handles host command writes for a buffered program operation on a parallel NOR-style flash. The host opens a buffer with a setup command and reads a buffer-available bit. It then gives the word count as N-1 and writes N data words. A confirm command must follow before the block starts its internal program sequence into an on-chip register-array model. Programming takes one clock per word and can only clear bits: each array word becomes the old word ANDed with the new data. After each word a verify compares the stored result with the requested data.

A status register reports a ready bit and error flags. Each flag is set by a distinct cause: a bad command sequence, an erase-block crossing, low program voltage, a locked block, or a bit that failed to program. Once a sequence or program error is latched, every further buffer-write setup is refused until the host issues clear-status. A read port returns array data, the status register, or the buffer-available word, depending on the last command. The busy pin is the inverse of the ready bit.

Top module: `bufwr_seq`

## Requirements
- R1: After reset, statusReg is 0x80, busy is 0, every array word reads 0xFFFF, and the read port is in array mode.
- R2: Command 0xE8 (low byte of wrData) while no error is latched is accepted. Reads then return 0x0080 (bit 7 = buffer available). The next write gives N-1 in wrData[3:0]. The next N writes are data words, and the address of the first data write is the start address.
- R3: Command 0xD0 after the last data word, with no fault, makes busy 1 for exactly N clock cycles. Each array word start+i then holds (old & data_i), and statusReg returns to 0x80.
- R4: Any code other than 0xD0 after the last data word aborts the operation. It sets SR5 and SR4 (statusReg = 0xB0) and leaves the array unchanged.
- R5: If start[4:0] + N - 1 exceeds 31 (32-word blocks), confirm aborts with SR5 and SR4 set (0xB0). The array is unchanged. This check takes priority over the voltage and lock checks.
- R6: If progVoltOk is 0 at confirm, SR4 and SR3 are set (0x98) and the array is unchanged. This check takes priority over the lock check.
- R7: If blockLock[start[6:5]] is 1 at confirm, SR4 and SR1 are set (0x92) and the array is unchanged.
- R8: If a programmed word reads back different from its requested data, SR4 is set (0x90) and the sequence stops. The failing word keeps the AND result and later words stay unchanged.
- R9: While SR4 or SR5 is set, 0xE8 is refused. Reads return 0x0000 (bit 7 = 0). The following writes are treated as commands, no program starts, and the array and status are unchanged.
- R10: Command 0x50 while idle clears SR5, SR4, SR3 and SR1, leaving statusReg = 0x80.
- R11: Command 0xFF selects array mode, where rdData = array[rdAddr]. After a confirm or an abort, reads return {0x00, statusReg}.
- R12: busy equals the inverse of statusReg bit 7 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe, one cycle per write |
| wrData | input | 16 | Command code (low byte), count or data word |
| wrAddr | input | 7 | Write address; the first data write gives the start |
| progVoltOk | input | 1 | Program voltage good |
| blockLock | input | 4 | Per-block lock bits |
| rdAddr | input | 7 | Array read address |
| rdData | output | 16 | Array word, status or buffer-available word |
| statusReg | output | 8 | Status register (bit 7 ready) |
| busy | output | 1 | High while the internal program runs |

## Verification
Clean programs are run with a short buffer, a full 16-word buffer that ends exactly on a block's last word, and programs over already-programmed data. These show whether the one-clock-per-word timing, the count handling and the AND behaviour are right. Each error cause is raised on its own. The boundary and voltage faults are also raised together with lower-priority faults, which shows whether the flag encoding follows cause and priority. A full setup, count, data and confirm sequence is then sent while an error is latched, which shows whether refused setups leave the array and the status alone. The verify-failure case shows whether programming stops at the failing word.

// File: rtl/bufwr_pkg.sv
package bufwr_pkg;
  localparam logic [7:0] CMD_SETUP   = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;

  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_XSR} rdMode_t;

  typedef struct packed {
    logic loadCount;
    logic pushWord;
    logic startProg;
    logic stepProg;
  } ctlStrobes_t;
endpackage

// File: rtl/bufwr_dpath.sv
module bufwr_dpath
  import bufwr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BUF_DEPTH = 16,
  parameter int BLOCK_WORDS = 32,
  parameter int NUM_BLOCKS = 4,
  localparam int ADDR_W = $clog2(BLOCK_WORDS * NUM_BLOCKS),
  localparam int PTR_W = $clog2(BUF_DEPTH),
  localparam int OFF_W = $clog2(BLOCK_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [NUM_BLOCKS-1:0] blockLock,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdWord,
  output logic              lastPush,
  output logic              lastProg,
  output logic              crossErr,
  output logic              lockHit,
  output logic              verifyBad
);
  localparam int MEM_WORDS = BLOCK_WORDS * NUM_BLOCKS;

  logic [DATA_W-1:0] mem [MEM_WORDS];
  logic [DATA_W-1:0] bufMem [BUF_DEPTH];
  logic [PTR_W-1:0]  count, wrPtr, prIdx;
  logic [ADDR_W-1:0] startAddr, progAddr;
  logic [OFF_W:0]    endOff;
  logic [DATA_W-1:0] andWord;

  assign progAddr  = startAddr + {{(ADDR_W-PTR_W){1'b0}}, prIdx};
  assign andWord   = mem[progAddr] & bufMem[prIdx];
  assign verifyBad = andWord != bufMem[prIdx];
  assign endOff    = {1'b0, startAddr[OFF_W-1:0]} + {{(OFF_W+1-PTR_W){1'b0}}, count};
  assign crossErr  = endOff[OFF_W];
  assign lockHit   = blockLock[startAddr[ADDR_W-1:OFF_W]];
  assign lastPush  = wrPtr == count;
  assign lastProg  = prIdx == count;
  assign rdWord    = mem[rdAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      wrPtr     <= '0;
      prIdx     <= '0;
      startAddr <= '0;
    end else begin
      if (strobes.loadCount) begin
        count <= wrData[PTR_W-1:0];
        wrPtr <= '0;
      end
      if (strobes.pushWord) begin
        if (wrPtr == '0) startAddr <= wrAddr;
        wrPtr <= wrPtr + 1'b1;
      end
      if (strobes.startProg) prIdx <= '0;
      if (strobes.stepProg) prIdx <= prIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.pushWord) bufMem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '1;
    end else if (strobes.stepProg) begin
      mem[progAddr] <= andWord;
    end
  end
endmodule

// File: rtl/bufwr_ctrl.sv
module bufwr_ctrl
  import bufwr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  cmdCode,
  input  logic        progVoltOk,
  input  logic        lastPush,
  input  logic        lastProg,
  input  logic        crossErr,
  input  logic        lockHit,
  input  logic        verifyBad,
  output ctlStrobes_t strobes,
  output rdMode_t     rdMode,
  output logic        bufAvail,
  output logic [7:0]  srBits
);
  typedef enum logic [2:0] {S_IDLE, S_COUNT, S_DATA, S_CONFIRM, S_PROG} state_t;

  state_t state;
  logic seqErr, progErr, voltErr, lockErr;
  logic faultFree;

  assign faultFree = !crossErr && progVoltOk && !lockHit;
  assign srBits = {state != S_PROG, 1'b0, seqErr, progErr, voltErr, 1'b0, lockErr, 1'b0};

  always_comb begin
    strobes = '0;
    case (state)
      S_COUNT:   strobes.loadCount = wrEn;
      S_DATA:    strobes.pushWord  = wrEn;
      S_CONFIRM: strobes.startProg = wrEn && cmdCode == CMD_CONFIRM && faultFree;
      S_PROG:    strobes.stepProg  = 1'b1;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      rdMode   <= RD_ARRAY;
      bufAvail <= 1'b0;
      seqErr   <= 1'b0;
      progErr  <= 1'b0;
      voltErr  <= 1'b0;
      lockErr  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (wrEn) begin
          case (cmdCode)
            CMD_SETUP: begin
              rdMode <= RD_XSR;
              if (seqErr || progErr) bufAvail <= 1'b0;
              else begin
                bufAvail <= 1'b1;
                state    <= S_COUNT;
              end
            end
            CMD_CLEAR: begin
              seqErr  <= 1'b0;
              progErr <= 1'b0;
              voltErr <= 1'b0;
              lockErr <= 1'b0;
              rdMode  <= RD_STATUS;
            end
            CMD_ARRAY: rdMode <= RD_ARRAY;
            default: ;
          endcase
        end
        S_COUNT: if (wrEn) state <= S_DATA;
        S_DATA:  if (wrEn && lastPush) state <= S_CONFIRM;
        S_CONFIRM: if (wrEn) begin
          rdMode   <= RD_STATUS;
          bufAvail <= 1'b0;
          state    <= S_IDLE;
          if (cmdCode != CMD_CONFIRM || crossErr) begin
            seqErr  <= 1'b1;
            progErr <= 1'b1;
          end else if (!progVoltOk) begin
            voltErr <= 1'b1;
            progErr <= 1'b1;
          end else if (lockHit) begin
            lockErr <= 1'b1;
            progErr <= 1'b1;
          end else begin
            state <= S_PROG;
          end
        end
        S_PROG: begin
          if (verifyBad) begin
            progErr <= 1'b1;
            state   <= S_IDLE;
          end else if (lastProg) begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bufwr_seq.sv
module bufwr_seq
  import bufwr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BUF_DEPTH = 16,
  parameter int BLOCK_WORDS = 32,
  parameter int NUM_BLOCKS = 4,
  localparam int ADDR_W = $clog2(BLOCK_WORDS * NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic                  progVoltOk,
  input  logic [NUM_BLOCKS-1:0] blockLock,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [DATA_W-1:0]     rdData,
  output logic [7:0]            statusReg,
  output logic                  busy
);
  ctlStrobes_t strobes;
  rdMode_t     rdMode;
  logic        bufAvail, lastPush, lastProg, crossErr, lockHit, verifyBad;
  logic [DATA_W-1:0] rdWord;

  bufwr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .cmdCode(wrData[7:0]),
    .progVoltOk(progVoltOk), .lastPush(lastPush), .lastProg(lastProg),
    .crossErr(crossErr), .lockHit(lockHit), .verifyBad(verifyBad),
    .strobes(strobes), .rdMode(rdMode), .bufAvail(bufAvail), .srBits(statusReg)
  );

  bufwr_dpath #(
    .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH),
    .BLOCK_WORDS(BLOCK_WORDS), .NUM_BLOCKS(NUM_BLOCKS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData), .wrAddr(wrAddr),
    .blockLock(blockLock), .rdAddr(rdAddr), .rdWord(rdWord),
    .lastPush(lastPush), .lastProg(lastProg), .crossErr(crossErr),
    .lockHit(lockHit), .verifyBad(verifyBad)
  );

  assign busy = ~statusReg[7];

  always_comb begin
    case (rdMode)
      RD_STATUS: rdData = {{(DATA_W-8){1'b0}}, statusReg};
      RD_XSR:    rdData = {{(DATA_W-8){1'b0}}, bufAvail, 7'b0};
      default:   rdData = rdWord;
    endcase
  end
endmodule

// File: rtl/bufwr_seq_chk.sv
module bufwr_seq_chk #(
  parameter int BUF_DEPTH = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic [7:0] statusReg
);
  int busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= 0;
    else if (busy) busyCnt <= busyCnt + 1;
    else busyCnt <= 0;
  end

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN) busyCnt <= BUF_DEPTH);

  // R9
  no_start_on_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !($past(statusReg[4]) || $past(statusReg[5])));

  // R5
  err_needs_sr4_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg[5] || statusReg[3] || statusReg[1]) |-> statusReg[4]);

  // R4
  seq_err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[5]) |-> !busy);

  // R10
  clear_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusReg[4]) |-> (!statusReg[5] && !statusReg[3] && !statusReg[1]));
endmodule

bind bufwr_seq bufwr_seq_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .statusReg(statusReg)
);

// File: tb/bufwr_seq_tb.sv
`timescale 1ns/1ps
module bufwr_seq_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0;
  logic [15:0] wrData = 0;
  logic [6:0]  wrAddr = 0;
  logic        progVoltOk = 1;
  logic [3:0]  blockLock = 0;
  logic [6:0]  rdAddr = 0;
  logic [15:0] rdData;
  logic [7:0]  statusReg;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] model [128];

  always #4 clk = ~clk;

  bufwr_seq u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrAddr(wrAddr),
    .progVoltOk(progVoltOk), .blockLock(blockLock), .rdAddr(rdAddr),
    .rdData(rdData), .statusReg(statusReg), .busy(busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d, input logic [6:0] a);
    @(negedge clk);
    wrEn = 1; wrData = d; wrAddr = a;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic checkMem(input string tag);
    int bad = 0;
    wr(16'h00FF, 0);
    for (int i = 0; i < 128; i++) begin
      rdAddr = i[6:0];
      #1;
      if (rdData !== model[i]) bad++;
    end
    check(tag, bad, 0);
  endtask

  task automatic loadBuf(input logic [6:0] start, input int n, input logic [15:0] seed);
    wr(16'h00E8, start);
    wr(16'(n - 1), start);
    for (int i = 0; i < n; i++) wr(seed + 16'(i * 16'h0101), start + 7'(i));
  endtask

  task automatic waitBusy(output int cnt);
    cnt = 0;
    while (busy && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic clearStatus();
    wr(16'h0050, 0);
    check("R10 clear", statusReg, 8'h80);
  endtask

  task automatic tReset();
    check("R1 status", statusReg, 8'h80);
    check("R1 busy", busy, 0);
    rdAddr = 7'd5; #1;
    check("R1 array read", rdData, 16'hFFFF);
    checkMem("R1 erased");
  endtask

  task automatic tGood();
    int cnt;
    logic [15:0] d [4] = '{16'h0F0F, 16'h00FF, 16'hA5A5, 16'h1234};
    wr(16'h00E8, 8);
    check("R2 xsr avail", rdData, 16'h0080);
    wr(16'h0003, 8);
    for (int i = 0; i < 4; i++) wr(d[i], 7'(8 + i));
    wr(16'h00D0, 8);
    check("R3 busy after confirm", busy, 1);
    check("R12 sr7 low", statusReg[7], 0);
    waitBusy(cnt);
    check("R3 cycles n=4", cnt, 4);
    check("R3 status", statusReg, 8'h80);
    check("R11 status read", rdData, 16'h0080);
    for (int i = 0; i < 4; i++) model[8 + i] = model[8 + i] & d[i];
    checkMem("R3 array n=4");
  endtask

  task automatic tFull();
    int cnt;
    loadBuf(7'd16, 16, 16'h1357);
    wr(16'h00D0, 16);
    waitBusy(cnt);
    check("R3 cycles n=16", cnt, 16);
    check("R5 end on last word ok", statusReg, 8'h80);
    for (int i = 0; i < 16; i++) model[16 + i] = model[16 + i] & (16'h1357 + 16'(i * 16'h0101));
    checkMem("R3 array n=16");
  endtask

  task automatic tCross();
    loadBuf(7'd24, 10, 16'h2020);
    progVoltOk = 0;
    wr(16'h00D0, 24);
    progVoltOk = 1;
    check("R5 crossing", statusReg, 8'hB0);
    check("R12 busy idle", busy, 0);
    checkMem("R5 array kept");
    clearStatus();
  endtask

  task automatic tBadConfirm();
    loadBuf(7'd40, 3, 16'h3030);
    wr(16'h0055, 40);
    check("R4 bad confirm", statusReg, 8'hB0);
    checkMem("R4 array kept");
    clearStatus();
  endtask

  task automatic tVolt();
    loadBuf(7'd64, 2, 16'h4040);
    progVoltOk = 0;
    blockLock = 4'b0100;
    wr(16'h00D0, 64);
    progVoltOk = 1;
    check("R6 low voltage", statusReg, 8'h98);
    checkMem("R6 array kept");
    clearStatus();
  endtask

  task automatic tLock();
    loadBuf(7'd70, 2, 16'h4141);
    wr(16'h00D0, 70);
    check("R7 locked", statusReg, 8'h92);
    checkMem("R7 array kept");
  endtask

  task automatic tRefused();
    wr(16'h00E8, 100);
    check("R9 xsr refused", rdData, 16'h0000);
    wr(16'h0003, 100);
    for (int i = 0; i < 4; i++) wr(16'h1111, 7'(100 + i));
    wr(16'h00D0, 100);
    check("R9 no busy", busy, 0);
    check("R9 status kept", statusReg, 8'h92);
    checkMem("R9 array kept");
    blockLock = 0;
    clearStatus();
  endtask

  task automatic tVerify();
    int cnt;
    wr(16'h00E8, 8);
    wr(16'h0002, 8);
    wr(16'h0F00, 8);
    wr(16'h0F00, 9);
    wr(16'h0000, 10);
    wr(16'h00D0, 8);
    waitBusy(cnt);
    check("R8 stop cycles", cnt, 2);
    check("R8 status", statusReg, 8'h90);
    model[8] = 16'h0F00;
    model[9] = 16'h0000;
    checkMem("R8 array");
    clearStatus();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tGood();
    tFull();
    tCross();
    tBadConfirm();
    tVolt();
    tLock();
    tRefused();
    tVerify();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule